// File: doc/BRIEF.md
# Instruction-Driven Byte Copy Engine

This block takes one 32-bit copy instruction on a start strobe and carries it out by itself. It splits the word into an opcode, three register indices and an 11-bit immediate. It presents the indices to a register file and captures the source base, byte count and destination base on the start cycle. Two opcode bits independently choose whether the shared immediate is added to the source base, to the destination base, to both, or to neither.

Once started, the engine walks both address ranges upward, one byte at a time. For each byte it issues a read and then a write on a byte-wide memory port, and each of the two handshakes may stall on its own ready signal. Busy is high while a copy runs, and done pulses once at the end. A start that carries an opcode outside the copy family is refused with a one-cycle illegal flag, and nothing else happens.

Top module: `copy_engine`

## Requirements
- R1: The register index outputs follow the instruction word: source-base index from bits 25:21, size index from bits 20:16, destination-base index from bits 15:11.
- R2: A start whose opcode (bits 31:26) is not one of 110000, 110001, 110010 or 110011 causes no memory access and leaves busy low. The illegal output is high for exactly the one cycle after that start.
- R3: The source start address is the source register value when bit 27 is 0, and that value plus the immediate when bit 27 is 1.
- R4: The destination start address is the destination register value when bit 26 is 0, and that value plus the immediate when bit 26 is 1.
- R5: The immediate (bits 10:0) is zero-extended, so offsets up to 2047 apply. When bits 27 and 26 are both set, the same immediate is added to both bases.
- R6: Exactly N bytes are moved, where N is the size register value. Write k (k = 0..N-1) goes to destination start + k and carries the byte read from source start + k, in ascending order.
- R7: A legal start with a size of zero makes no memory access and keeps busy low. Done is high in the cycle after the start.
- R8: Register values are captured on the start cycle, so later register changes do not affect the copy. A start (legal or not) while busy is high is ignored, including the illegal flag.
- R9: A read request holds its address until ready is seen, and a write request holds its address and data until ready is seen. Read and write requests are never high together, and each byte is read before it is written.
- R10: Busy is high from the cycle after an accepted non-zero start until the final write is accepted. Done is high for exactly the one cycle after the final write is accepted, with busy low.
- R11: After reset, busy, done, illegal and both memory requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe for the instruction word |
| instr | input | 32 | Copy instruction word |
| rf_src_idx | output | 5 | Register index of the source base |
| rf_len_idx | output | 5 | Register index of the byte count |
| rf_dst_idx | output | 5 | Register index of the destination base |
| rf_src_val | input | AW | Source base register value |
| rf_len_val | input | AW | Byte count register value |
| rf_dst_val | input | AW | Destination base register value |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for a refused opcode |
| mem_rd_req | output | 1 | Read request |
| mem_rd_addr | output | AW | Read byte address |
| mem_rd_ready | input | 1 | Read accepted, data valid |
| mem_rd_data | input | 8 | Read data |
| mem_wr_req | output | 1 | Write request |
| mem_wr_addr | output | AW | Write byte address |
| mem_wr_data | output | 8 | Write data |
| mem_wr_ready | input | 1 | Write accepted |

## Verification
The bench runs all four offset variants. It uses a non-zero immediate with both flags clear, so an engine that added the offset regardless of the flags would write to shifted addresses. It also uses the largest immediate, 2047, which catches an offset that was truncated or sign-extended.

A zero-length copy must finish at once. A design that decremented first would wrap the count and write without end.

Refused opcodes must pulse the illegal flag without starting. A second start arrives mid-copy while the register values change under the engine. A design that restarted or re-read the registers would produce writes the scoreboard does not expect.

Random ready stalls on both sides expose a design that advances an address before its handshake completes. Done is timed against the last accepted write, which catches a completion pulse that is one cycle early or late.

// File: rtl/copy_engine_pkg.sv
package copy_engine_pkg;
    localparam int OPW  = 6;
    localparam int IDXW = 5;
    localparam int IMMW = 11;
    localparam logic [3:0] OP_FAMILY = 4'b1100;

    typedef struct packed {
        logic [IDXW-1:0] src_idx;
        logic [IDXW-1:0] len_idx;
        logic [IDXW-1:0] dst_idx;
        logic [IMMW-1:0] imm;
        logic            legal;
        logic            src_off;
        logic            dst_off;
    } instr_fields_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_READ  = 2'd1,
        SQ_WRITE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/cpy_decode.sv
module cpy_decode
    import copy_engine_pkg::*;
(
    input  logic [31:0]   instr,
    output instr_fields_t fields
);
    always_comb begin
        fields.legal   = (instr[31:28] == OP_FAMILY);
        fields.src_off = instr[27];
        fields.dst_off = instr[26];
        fields.src_idx = instr[25:21];
        fields.len_idx = instr[20:16];
        fields.dst_idx = instr[15:11];
        fields.imm     = instr[IMMW-1:0];
    end
endmodule

// File: rtl/cpy_addr.sv
module cpy_addr
    import copy_engine_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]   src_base,
    input  logic [AW-1:0]   dst_base,
    input  logic [IMMW-1:0] imm,
    input  logic            src_off,
    input  logic            dst_off,
    output logic [AW-1:0]   src_start,
    output logic [AW-1:0]   dst_start
);
    localparam int PADW = AW - IMMW;

    logic [AW-1:0] imm_ext;

    generate
        if (PADW > 0) begin : g_pad
            assign imm_ext = {{PADW{1'b0}}, imm};
        end else begin : g_trunc
            assign imm_ext = imm[AW-1:0];
        end
    endgenerate

    always_comb begin
        src_start = src_base + (src_off ? imm_ext : '0);
        dst_start = dst_base + (dst_off ? imm_ext : '0);
    end
endmodule

// File: rtl/cpy_seq.sv
module cpy_seq
    import copy_engine_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          legal,
    input  logic [AW-1:0] src_start,
    input  logic [AW-1:0] dst_start,
    input  logic [AW-1:0] len,
    output logic          busy,
    output logic          done,
    output logic          illegal,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ready,
    input  logic [DW-1:0] rd_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    input  logic          wr_ready
);
    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] cnt;
        logic [DW-1:0] data;
        logic          done;
        logic          bad;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.bad  = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                if (start) begin
                    if (!legal) begin
                        d.bad = 1'b1;
                    end else if (len == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st  = SQ_READ;
                        d.src = src_start;
                        d.dst = dst_start;
                        d.cnt = len;
                    end
                end
            end
            SQ_READ: begin
                if (rd_ready) begin
                    d.data = rd_data;
                    d.st   = SQ_WRITE;
                end
            end
            SQ_WRITE: begin
                if (wr_ready) begin
                    d.src = q.src + AW'(1);
                    d.dst = q.dst + AW'(1);
                    d.cnt = q.cnt - AW'(1);
                    if (q.cnt == AW'(1)) begin
                        d.st   = SQ_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st = SQ_READ;
                    end
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != SQ_IDLE);
    assign done    = q.done;
    assign illegal = q.bad;
    assign rd_req  = (q.st == SQ_READ);
    assign rd_addr = q.src;
    assign wr_req  = (q.st == SQ_WRITE);
    assign wr_addr = q.dst;
    assign wr_data = q.data;
endmodule

// File: rtl/copy_engine.sv
module copy_engine
    import copy_engine_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [31:0]   instr,
    output logic [4:0]    rf_src_idx,
    output logic [4:0]    rf_len_idx,
    output logic [4:0]    rf_dst_idx,
    input  logic [AW-1:0] rf_src_val,
    input  logic [AW-1:0] rf_len_val,
    input  logic [AW-1:0] rf_dst_val,
    output logic          busy,
    output logic          done,
    output logic          illegal,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_ready,
    input  logic [7:0]    mem_rd_data,
    output logic          mem_wr_req,
    output logic [AW-1:0] mem_wr_addr,
    output logic [7:0]    mem_wr_data,
    input  logic          mem_wr_ready
);
    instr_fields_t f;
    logic [AW-1:0] src_start, dst_start;

    cpy_decode u_dec (
        .instr  (instr),
        .fields (f)
    );

    assign rf_src_idx = f.src_idx;
    assign rf_len_idx = f.len_idx;
    assign rf_dst_idx = f.dst_idx;

    cpy_addr #(.AW(AW)) u_addr (
        .src_base  (rf_src_val),
        .dst_base  (rf_dst_val),
        .imm       (f.imm),
        .src_off   (f.src_off),
        .dst_off   (f.dst_off),
        .src_start (src_start),
        .dst_start (dst_start)
    );

    cpy_seq #(.AW(AW), .DW(8)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .legal     (f.legal),
        .src_start (src_start),
        .dst_start (dst_start),
        .len       (rf_len_val),
        .busy      (busy),
        .done      (done),
        .illegal   (illegal),
        .rd_req    (mem_rd_req),
        .rd_addr   (mem_rd_addr),
        .rd_ready  (mem_rd_ready),
        .rd_data   (mem_rd_data),
        .wr_req    (mem_wr_req),
        .wr_addr   (mem_wr_addr),
        .wr_data   (mem_wr_data),
        .wr_ready  (mem_wr_ready)
    );
endmodule

// File: rtl/copy_engine_checker.sv
module copy_engine_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [31:0]   instr,
    input logic [AW-1:0] rf_len_val,
    input logic          busy,
    input logic          done,
    input logic          illegal,
    input logic          mem_rd_req,
    input logic [AW-1:0] mem_rd_addr,
    input logic          mem_rd_ready,
    input logic          mem_wr_req,
    input logic [AW-1:0] mem_wr_addr,
    input logic [7:0]    mem_wr_data,
    input logic          mem_wr_ready
);
    a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && instr[31:28] != 4'b1100) |=> (illegal && !busy && !mem_rd_req));

    a_r2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal);

    a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && instr[31:28] == 4'b1100 && rf_len_val == '0) |=> (done && !busy));

    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(mem_wr_req && mem_wr_ready)) |=> busy);

    a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ready) |=> (mem_rd_req && $stable(mem_rd_addr)));

    a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ready) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));

    a_r9_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_ready) |=> mem_wr_req);

    a_r6_src_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && mem_wr_ready) |=> (!mem_rd_req || mem_rd_addr == $past(mem_rd_addr) + AW'(1)));

    a_r6_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && mem_wr_ready) |=> (!mem_rd_req || mem_wr_addr == $past(mem_wr_addr) + AW'(1)));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind copy_engine copy_engine_checker #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .instr        (instr),
    .rf_len_val   (rf_len_val),
    .busy         (busy),
    .done         (done),
    .illegal      (illegal),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_ready (mem_rd_ready),
    .mem_wr_req   (mem_wr_req),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_ready (mem_wr_ready)
);

// File: tb/copy_engine_bench.sv
module copy_engine_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   instr = '0;
    logic [4:0]    rf_src_idx, rf_len_idx, rf_dst_idx;
    logic [AW-1:0] rf_src_val, rf_len_val, rf_dst_val;
    logic          busy, done, illegal;
    logic          mem_rd_req, mem_wr_req;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [7:0]    mem_rd_data, mem_wr_data;
    logic          mem_rd_ready = 1'b0;
    logic          mem_wr_ready = 1'b0;

    logic [31:0] regs [0:31];
    logic [7:0]  mem  [0:65535];

    typedef struct {
        logic [31:0] a;
        logic [7:0]  d;
    } item_t;
    item_t exp_q[$];

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int last_acc = -10;
    int wr_cnt   = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign rf_src_val  = regs[rf_src_idx];
    assign rf_len_val  = regs[rf_len_idx];
    assign rf_dst_val  = regs[rf_dst_idx];
    assign mem_rd_data = mem[mem_rd_addr[15:0]];

    copy_engine #(.AW(AW)) u_copy_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .rf_src_idx(rf_src_idx), .rf_len_idx(rf_len_idx), .rf_dst_idx(rf_dst_idx),
        .rf_src_val(rf_src_val), .rf_len_val(rf_len_val), .rf_dst_val(rf_dst_val),
        .busy(busy), .done(done), .illegal(illegal),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // monitor: memory model with random stalls and scoreboard pop
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_rd_ready = lfsr[0] | lfsr[3];
        mem_wr_ready = lfsr[5] | lfsr[8];
        #1;
        if (rst_n && mem_wr_req && mem_wr_ready) begin
            wr_cnt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6/R8", "unexpected write addr", mem_wr_addr, 32'hFFFF_FFFF);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(mem_wr_addr == it.a, "R6", "write address", mem_wr_addr, it.a);
                chk(mem_wr_data == it.d, "R6", "write data", {24'd0, mem_wr_data}, {24'd0, it.d});
                if (exp_q.size() == 0) last_acc = cyc;
            end
            mem[mem_wr_addr[15:0]] = mem_wr_data;
        end
    end

    function automatic logic [31:0] mk(input logic [5:0] op, input int rs, input int rt,
                                       input int rd, input logic [10:0] imm);
        return {op, 5'(rs), 5'(rt), 5'(rd), imm};
    endfunction

    task automatic pulse_start(input logic [31:0] w);
        @(negedge clk);
        instr = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_copy(input logic [5:0] op, input int rs, input int rt, input int rd,
                            input logic [10:0] imm, input string req, input bit disturb);
        logic [31:0] s, dd, n, old;
        bit seen;
        s  = regs[rs] + (op[1] ? {21'd0, imm} : 32'd0);
        dd = regs[rd] + (op[0] ? {21'd0, imm} : 32'd0);
        n  = regs[rt];
        for (int k = 0; k < int'(n); k++) begin
            item_t it;
            it.a = dd + 32'(k);
            it.d = mem[16'(s + 32'(k))];
            exp_q.push_back(it);
        end
        wr_cnt = 0;
        pulse_start(mk(op, rs, rt, rd, imm));
        #2;
        chk(busy == 1'b1, "R10", "busy after start", {31'd0, busy}, 32'd1);
        old = regs[rs];
        if (disturb) begin
            // R8: registers change and new starts arrive while busy
            regs[rs] = 32'h7000;
            regs[rt] = 32'd3;
            pulse_start(mk(6'b110011, 9, 2, 4, 11'd5));
            pulse_start(mk(6'b111000, 1, 2, 3, 11'd0));
            #2;
            chk(illegal == 1'b0, "R8", "illegal flag while busy", {31'd0, illegal}, 32'd0);
        end
        seen = 0;
        for (int t = 0; t < 4000 && !seen; t++) begin
            @(negedge clk);
            #2;
            if (done) seen = 1;
        end
        chk(seen, req, "done seen", {31'd0, seen}, 32'd1);
        chk(busy == 1'b0, "R10", "busy low with done", {31'd0, busy}, 32'd0);
        chk(cyc == last_acc + 1, "R10", "done one cycle after last write", 32'(cyc), 32'(last_acc + 1));
        @(negedge clk);
        #2;
        chk(done == 1'b0, "R10", "done is one cycle", {31'd0, done}, 32'd0);
        chk(exp_q.size() == 0, req, "all bytes written", 32'(exp_q.size()), 32'd0);
        chk(wr_cnt == int'(n), "R6", "write count", 32'(wr_cnt), n);
        if (disturb) begin
            regs[rs] = old;
            regs[rt] = n;
        end
        exp_q.delete();
    endtask

    task automatic try_illegal(input logic [5:0] op);
        pulse_start(mk(op, 1, 2, 3, 11'd0));
        #2;
        chk(illegal == 1'b1, "R2", "illegal pulse", {31'd0, illegal}, 32'd1);
        chk(busy == 1'b0 && mem_rd_req == 1'b0, "R2", "no launch", {30'd0, busy, mem_rd_req}, 32'd0);
        @(negedge clk);
        #2;
        chk(illegal == 1'b0, "R2", "illegal one cycle", {31'd0, illegal}, 32'd0);
        chk(busy == 1'b0, "R2", "still idle", {31'd0, busy}, 32'd0);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = 32'd0;
        for (int i = 0; i < 65536; i++) mem[i] = 8'(i * 7 + 3) ^ 8'(i >> 8);
        regs[1] = 32'h1000; regs[2] = 32'd5;  regs[3] = 32'h2000;
        regs[4] = 32'h3000; regs[5] = 32'h1100; regs[6] = 32'd9;
        regs[7] = 32'h4000; regs[8] = 32'h5000; regs[9] = 32'd0;
        regs[10] = 32'd17; regs[11] = 32'h6000;

        repeat (3) @(negedge clk);
        #2;
        chk(busy == 0 && done == 0 && illegal == 0, "R11", "status in reset",
            {29'd0, busy, done, illegal}, 32'd0);
        chk(mem_rd_req == 0 && mem_wr_req == 0, "R11", "requests in reset",
            {30'd0, mem_rd_req, mem_wr_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(busy == 0 && done == 0 && illegal == 0, "R11", "status after reset",
            {29'd0, busy, done, illegal}, 32'd0);

        // R1: index fields
        instr = mk(6'b110000, 21, 14, 7, 11'h3AB);
        #1;
        chk(rf_src_idx == 5'd21, "R1", "source index", 32'(rf_src_idx), 32'd21);
        chk(rf_len_idx == 5'd14, "R1", "size index", 32'(rf_len_idx), 32'd14);
        chk(rf_dst_idx == 5'd7, "R1", "destination index", 32'(rf_dst_idx), 32'd7);

        run_copy(6'b110000, 1, 2, 3, 11'd500, "R3/R4", 0);   // imm ignored
        run_copy(6'b110001, 1, 2, 4, 11'd100, "R4", 0);      // dst + imm
        run_copy(6'b110010, 5, 6, 7, 11'h40, "R3", 0);       // src + imm
        run_copy(6'b110011, 1, 6, 8, 11'd2047, "R5", 0);     // both, max imm
        run_copy(6'b110000, 5, 10, 11, 11'd0, "R6", 0);      // longer run

        // R7: zero size
        wr_cnt = 0;
        pulse_start(mk(6'b110011, 1, 9, 3, 11'd12));
        #2;
        chk(done == 1'b1, "R7", "done next cycle", {31'd0, done}, 32'd1);
        chk(busy == 1'b0, "R7", "busy stays low", {31'd0, busy}, 32'd0);
        @(negedge clk);
        #2;
        chk(done == 1'b0 && wr_cnt == 0, "R7", "no writes, single pulse", 32'(wr_cnt), 32'd0);

        // R2: refused opcodes
        try_illegal(6'b110100);
        try_illegal(6'b000000);
        try_illegal(6'b111111);
        try_illegal(6'b010011);

        // R8: capture and ignore while busy
        regs[3] = 32'h8000;
        run_copy(6'b110001, 1, 2, 3, 11'd3, "R8", 1);

        repeat (3) @(negedge clk);
        #2;
        chk(busy == 1'b0 && wr_cnt == 5, "R8", "no late writes", 32'(wr_cnt), 32'd5);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule